// File: doc/BRIEF.md
# Static Direction Branch Predictor with ID-Stage Redirect

This block steers instruction fetch in a five-stage pipeline that resolves conditional branches in the decode stage. In the fetch stage it looks at the instruction just fetched. If that instruction is an equality branch whose offset is negative (a backward branch, such as a loop back edge), it predicts taken and sends fetch to the branch target. Any other instruction, including a forward branch, continues to the next sequential address with no delay. A mode input can force every prediction to not-taken, so the static scheme can be compared against the simplest one.

In the decode stage the block receives the branch's two register operands, the offset and the prediction bit that came down with it from fetch. It compares the operands and forms the real target. When the real outcome disagrees with the prediction, it raises a flush that squashes the single wrong-path instruction held between fetch and decode, and it overrides the fetch address with the correct path. A mispredict counter is kept for performance evaluation. The register file, the memories and the pipeline registers stay outside the block.

Top module: `static_dir_predictor`

## Requirements
- R1: When the fetched word is a branch (bits [31:26] equal 6'b000100) with offset bit [15] set and the not-taken mode is off, `fe_pred_taken_o` is 1 and `next_pc_o` equals `fe_pc_i + 4 + (sign-extended offset << 2)`, unless R6 applies.
- R2: A fetched branch with offset bit [15] clear (forward, including zero offset) gives `fe_pred_taken_o` = 0 and `next_pc_o` = `fe_pc_i + 4`, unless R6 applies.
- R3: A fetched word that is not a branch gives `fe_pred_taken_o` = 0 and `next_pc_o` = `fe_pc_i + 4`, unless R6 applies.
- R4: While `force_nt_i` is 1, `fe_pred_taken_o` is 0 for every fetched word, backward branches included.
- R5: A decode-stage branch is resolved taken exactly when `dc_src_a_i` equals `dc_src_b_i`; its target is `dc_pc_i + 4 + (sign-extended dc_offset_i << 2)`.
- R6: When a decode-stage branch resolves opposite to `dc_pred_taken_i`, `flush_o` is 1 and `next_pc_o` is the resolved path (target if taken, `dc_pc_i + 4` if not), overriding any fetch prediction.
- R7: When a decode-stage branch resolves as predicted, `flush_o` is 0 and `next_pc_o` follows the fetch-stage rules.
- R8: `miss_count_o` rises by one on each clock edge where `flush_o` is 1, and holds its value at the all-ones maximum instead of wrapping.
- R9: During reset `miss_count_o` is 0.
- R10: With `dc_branch_i` at 0, `flush_o` is 0 and the counter holds, whatever the operands and prediction bit are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_nt_i | input | 1 | Forces not-taken prediction for all branches |
| fe_pc_i | input | 32 | Address of the fetched instruction |
| fe_instr_i | input | 32 | Fetched instruction word |
| fe_pred_taken_o | output | 1 | Prediction for the fetched word, to be carried into the decode stage |
| dc_branch_i | input | 1 | Decode stage holds a valid equality branch |
| dc_pc_i | input | 32 | Address of the decode-stage branch |
| dc_offset_i | input | 16 | Word offset of the decode-stage branch |
| dc_src_a_i | input | 32 | First register operand |
| dc_src_b_i | input | 32 | Second register operand |
| dc_pred_taken_i | input | 1 | Prediction made for the decode-stage branch in fetch |
| next_pc_o | output | 32 | Address to load into the program counter |
| flush_o | output | 1 | Replace the fetch-to-decode instruction with a no-op |
| miss_count_o | output | 4 | Count of mispredicted branches (width set by CNT_W) |

## Verification
The fetch side is tried with a plain ALU word, a backward branch, a forward branch and a zero-offset branch, which separates the offset sign test from the opcode test and shows zero falls on the not-taken side; the same backward branch under forced not-taken mode shows the mode switch is honoured. The decode side is tried with all four pairings of predicted and actual outcome, so a flush that fires on correct predictions or a redirect to the wrong path (target versus fall-through) is caught, and with a mispredict coinciding with a backward fetch branch to show the decode redirect wins. A run of mispredicts drives the counter to its ceiling to tell saturation from wrap-around, and a mismatching operand pair with the branch flag low shows invalid decode slots are ignored.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   // Source of the next fetch address, in priority order
   typedef enum logic [1:0] {
      NPC_SEQUENTIAL = 2'd0,
      NPC_PREDICTED  = 2'd1,
      NPC_REPAIR     = 2'd2
   } npc_src_e;

   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned WORD_SHIFT  = 2;

endpackage

// File: rtl/sdp_fetch_guess.sv
module sdp_fetch_guess #(
   parameter int unsigned           ADDR_W  = 32,
   parameter int unsigned           INSTR_W = 32,
   parameter int unsigned           OFF_W   = 16,
   parameter int unsigned           OPC_LSB = 26,
   parameter int unsigned           OPC_W   = 6,
   parameter logic [OPC_W-1:0]      BR_OPC  = 6'b000100
) (
   input  logic               force_nt_i,
   input  logic [ADDR_W-1:0]  pc_i,
   input  logic [INSTR_W-1:0] instr_i,
   output logic               is_branch_o,
   output logic               guess_taken_o,
   output logic [ADDR_W-1:0]  seq_pc_o,
   output logic [ADDR_W-1:0]  guess_pc_o
);
   import sdp_pkg::*;

   localparam int unsigned EXT_W = ADDR_W - OFF_W - WORD_SHIFT;

   logic [OFF_W-1:0]  offset;
   logic [ADDR_W-1:0] byte_disp;
   logic              backward;
   logic              unused_bits;

   assign offset    = instr_i[OFF_W-1:0];
   assign backward  = offset[OFF_W-1];
   assign byte_disp = {{EXT_W{offset[OFF_W-1]}}, offset, {WORD_SHIFT{1'b0}}};

   assign is_branch_o   = (instr_i[OPC_LSB +: OPC_W] == BR_OPC);
   assign guess_taken_o = is_branch_o && backward && !force_nt_i;
   assign seq_pc_o      = pc_i + ADDR_W'(INSTR_BYTES);
   assign guess_pc_o    = seq_pc_o + byte_disp;

   generate
      if (OPC_LSB > OFF_W) begin : g_gap
         assign unused_bits = ^instr_i[OPC_LSB-1:OFF_W];
      end else begin : g_nogap
         assign unused_bits = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sdp_decode_resolve.sv
module sdp_decode_resolve #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned OFF_W    = 16,
   parameter bit          XOR_TREE = 1'b1
) (
   input  logic              branch_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [OFF_W-1:0]  offset_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic              pred_taken_i,
   output logic              taken_o,
   output logic              wrong_o,
   output logic [ADDR_W-1:0] repair_pc_o
);
   import sdp_pkg::*;

   localparam int unsigned EXT_W = ADDR_W - OFF_W - WORD_SHIFT;

   logic              operands_equal;
   logic [ADDR_W-1:0] fall_pc;
   logic [ADDR_W-1:0] target_pc;

   generate
      if (XOR_TREE) begin : g_xor_cmp
         logic [DATA_W-1:0] diff;
         assign diff           = src_a_i ^ src_b_i;
         assign operands_equal = ~|diff;
      end else begin : g_eq_cmp
         assign operands_equal = (src_a_i == src_b_i);
      end
   endgenerate

   assign fall_pc   = pc_i + ADDR_W'(INSTR_BYTES);
   assign target_pc = fall_pc + {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {WORD_SHIFT{1'b0}}};

   assign taken_o     = branch_i && operands_equal;
   assign wrong_o     = branch_i && (operands_equal != pred_taken_i);
   assign repair_pc_o = operands_equal ? target_pc : fall_pc;

endmodule

// File: rtl/sdp_miss_counter.sv
module sdp_miss_counter #(
   parameter int unsigned CNT_W    = 4,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            count_d = count_q;
            if (bump_i && (count_q != TOP)) count_d = count_q + 1'b1;
         end
      end else begin : g_wrap
         always_comb begin
            count_d = count_q;
            if (bump_i) count_d = count_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end

   assign count_o = count_q;

endmodule

// File: rtl/static_dir_predictor.sv
module static_dir_predictor #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned INSTR_W  = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned CNT_W    = 4,
   parameter bit          SATURATE = 1'b1,
   parameter bit          XOR_TREE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               force_nt_i,
   input  logic [ADDR_W-1:0]  fe_pc_i,
   input  logic [INSTR_W-1:0] fe_instr_i,
   output logic               fe_pred_taken_o,
   input  logic               dc_branch_i,
   input  logic [ADDR_W-1:0]  dc_pc_i,
   input  logic [OFF_W-1:0]   dc_offset_i,
   input  logic [DATA_W-1:0]  dc_src_a_i,
   input  logic [DATA_W-1:0]  dc_src_b_i,
   input  logic               dc_pred_taken_i,
   output logic [ADDR_W-1:0]  next_pc_o,
   output logic               flush_o,
   output logic [CNT_W-1:0]   miss_count_o
);
   import sdp_pkg::*;

   localparam int unsigned OPC_W   = 6;
   localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

   generate
      if (OFF_W + WORD_SHIFT >= ADDR_W) begin : g_bad_off
         initial $fatal(1, "offset too wide for address");
      end
      if (OFF_W + OPC_W > INSTR_W) begin : g_bad_instr
         initial $fatal(1, "instruction too narrow for opcode and offset");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         initial $fatal(1, "counter width must be positive");
      end
   endgenerate

   logic              fe_is_branch;
   logic              fe_guess;
   logic [ADDR_W-1:0] fe_seq_pc;
   logic [ADDR_W-1:0] fe_guess_pc;
   logic              dc_taken;
   logic              dc_wrong;
   logic [ADDR_W-1:0] dc_repair_pc;
   npc_src_e          npc_src;
   logic              unused_fe;
   logic              unused_dc;

   sdp_fetch_guess #(
      .ADDR_W (ADDR_W),
      .INSTR_W(INSTR_W),
      .OFF_W  (OFF_W),
      .OPC_LSB(OPC_LSB),
      .OPC_W  (OPC_W),
      .BR_OPC (6'b000100)
   ) u_fetch (
      .force_nt_i   (force_nt_i),
      .pc_i         (fe_pc_i),
      .instr_i      (fe_instr_i),
      .is_branch_o  (fe_is_branch),
      .guess_taken_o(fe_guess),
      .seq_pc_o     (fe_seq_pc),
      .guess_pc_o   (fe_guess_pc)
   );

   sdp_decode_resolve #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .OFF_W   (OFF_W),
      .XOR_TREE(XOR_TREE)
   ) u_resolve (
      .branch_i    (dc_branch_i),
      .pc_i        (dc_pc_i),
      .offset_i    (dc_offset_i),
      .src_a_i     (dc_src_a_i),
      .src_b_i     (dc_src_b_i),
      .pred_taken_i(dc_pred_taken_i),
      .taken_o     (dc_taken),
      .wrong_o     (dc_wrong),
      .repair_pc_o (dc_repair_pc)
   );

   sdp_miss_counter #(
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .bump_i (dc_wrong),
      .count_o(miss_count_o)
   );

   assign unused_fe = fe_is_branch;
   assign unused_dc = dc_taken;

   always_comb begin
      if (dc_wrong)      npc_src = NPC_REPAIR;
      else if (fe_guess) npc_src = NPC_PREDICTED;
      else               npc_src = NPC_SEQUENTIAL;
   end

   always_comb begin
      unique case (npc_src)
         NPC_REPAIR:    next_pc_o = dc_repair_pc;
         NPC_PREDICTED: next_pc_o = fe_guess_pc;
         default:       next_pc_o = fe_seq_pc;
      endcase
   end

   assign fe_pred_taken_o = fe_guess;
   assign flush_o         = dc_wrong;

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               force_nt_i,
   input logic [INSTR_W-1:0] fe_instr_i,
   input logic               fe_pred_taken_o,
   input logic               dc_branch_i,
   input logic [DATA_W-1:0]  dc_src_a_i,
   input logic [DATA_W-1:0]  dc_src_b_i,
   input logic               dc_pred_taken_i,
   input logic               flush_o,
   input logic [CNT_W-1:0]   miss_count_o
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   p_forced_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      force_nt_i |-> !fe_pred_taken_o);

   p_forward_nt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fe_instr_i[15] |-> !fe_pred_taken_o);

   p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> ((dc_src_a_i == dc_src_b_i) != dc_pred_taken_i));

   p_right_guess_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_branch_i && ((dc_src_a_i == dc_src_b_i) == dc_pred_taken_i)) |-> !flush_o);

   p_idle_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dc_branch_i |-> !flush_o);

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_o && miss_count_o != TOP) |=> miss_count_o == $past(miss_count_o) + 1'b1);

   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o || miss_count_o == TOP) |=> $stable(miss_count_o));

   always_comb begin
      if (!rst_n) begin
         a_reset_zero_r9: assert (miss_count_o == '0);
      end
   end

endmodule

bind static_dir_predictor sdp_checker #(
   .ADDR_W (ADDR_W),
   .INSTR_W(INSTR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_sdp_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .force_nt_i     (force_nt_i),
   .fe_instr_i     (fe_instr_i),
   .fe_pred_taken_o(fe_pred_taken_o),
   .dc_branch_i    (dc_branch_i),
   .dc_src_a_i     (dc_src_a_i),
   .dc_src_b_i     (dc_src_b_i),
   .dc_pred_taken_i(dc_pred_taken_i),
   .flush_o        (flush_o),
   .miss_count_o   (miss_count_o)
);

// File: tb/static_dir_predictor_test.sv
module static_dir_predictor_test;

   localparam int CNT_W = 4;

   typedef struct {
      logic [31:0]      npc;
      logic             pred;
      logic             flush;
      logic [CNT_W-1:0] cnt;
      string            tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              force_nt = 1'b0;
   logic [31:0]       fe_pc = '0;
   logic [31:0]       fe_instr = '0;
   logic              fe_pred;
   logic              dc_branch = 1'b0;
   logic [31:0]       dc_pc = '0;
   logic [15:0]       dc_off = '0;
   logic [31:0]       src_a = '0;
   logic [31:0]       src_b = '0;
   logic              dc_pred = 1'b0;
   logic [31:0]       next_pc;
   logic              flush;
   logic [CNT_W-1:0]  miss_cnt;

   int                n_checks = 0;
   int                n_fail = 0;
   int                model_cnt = 0;
   bit                done = 1'b0;
   exp_t              sb[$];

   always #10 clk = ~clk;

   static_dir_predictor #(.CNT_W(CNT_W)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .force_nt_i     (force_nt),
      .fe_pc_i        (fe_pc),
      .fe_instr_i     (fe_instr),
      .fe_pred_taken_o(fe_pred),
      .dc_branch_i    (dc_branch),
      .dc_pc_i        (dc_pc),
      .dc_offset_i    (dc_off),
      .dc_src_a_i     (src_a),
      .dc_src_b_i     (src_b),
      .dc_pred_taken_i(dc_pred),
      .next_pc_o      (next_pc),
      .flush_o        (flush),
      .miss_count_o   (miss_cnt)
   );

   function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] off);
      return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
   endfunction

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] beq(input logic [15:0] off);
      return {6'b000100, 5'd1, 5'd2, off};
   endfunction

   // Driver: applies one vector and pushes its expected outcome
   task automatic drive(input string tag, input logic fnt, input logic [31:0] fpc, input logic [31:0] fins,
                        input logic dbr, input logic [31:0] dpc, input logic [15:0] doff,
                        input logic [31:0] a, input logic [31:0] b, input logic dpr);
      exp_t e;
      logic is_br, guess, taken, wrong;
      @(negedge clk);
      #1;
      force_nt = fnt; fe_pc = fpc; fe_instr = fins; dc_branch = dbr;
      dc_pc = dpc; dc_off = doff; src_a = a; src_b = b; dc_pred = dpr;
      is_br = (fins[31:26] == 6'b000100);
      guess = is_br && fins[15] && !fnt;
      taken = (a == b);
      wrong = dbr && (taken != dpr);
      if (wrong)      e.npc = taken ? tgt(dpc, doff) : dpc + 32'd4;
      else if (guess) e.npc = tgt(fpc, fins[15:0]);
      else            e.npc = fpc + 32'd4;
      if (wrong && model_cnt < (2**CNT_W - 1)) model_cnt++;
      e.pred = guess; e.flush = wrong; e.cnt = CNT_W'(model_cnt); e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: samples shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "next_pc", next_pc, e.npc);
            check(e.tag, "pred", 32'(fe_pred), 32'(e.pred));
            check(e.tag, "flush", 32'(flush), 32'(e.flush));
            check(e.tag, "count", 32'(miss_cnt), 32'(e.cnt));
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 5000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   localparam logic [31:0] ALU_WORD = 32'h0022_1820;

   initial begin
      repeat (3) @(negedge clk);
      check("R9", "reset count", 32'(miss_cnt), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // Fetch-side prediction
      drive("R3", 0, 32'h100, ALU_WORD, 0, 0, 0, 0, 0, 0);
      drive("R1", 0, 32'h200, beq(16'hFFFC), 0, 0, 0, 0, 0, 0);
      drive("R2", 0, 32'h300, beq(16'h0008), 0, 0, 0, 0, 0, 0);
      drive("R2", 0, 32'h340, beq(16'h0000), 0, 0, 0, 0, 0, 0);
      drive("R4", 1, 32'h200, beq(16'hFFFC), 0, 0, 0, 0, 0, 0);
      drive("R4", 1, 32'h3F0, beq(16'h8000), 0, 0, 0, 0, 0, 0);
      // Decode-side resolution
      drive("R7", 0, 32'h400, ALU_WORD, 1, 32'h3FC, 16'hFFF0, 32'd5, 32'd5, 1);
      drive("R7", 0, 32'h404, ALU_WORD, 1, 32'h400, 16'h0010, 32'd5, 32'd6, 0);
      drive("R5", 0, 32'h500, ALU_WORD, 1, 32'h4FC, 16'h0020, 32'd9, 32'd9, 0);
      drive("R6", 0, 32'h600, ALU_WORD, 1, 32'h5FC, 16'hFFF8, 32'd1, 32'd2, 1);
      drive("R6", 0, 32'h700, beq(16'hFFF0), 1, 32'h6FC, 16'h0040, 32'hA, 32'hA, 0);
      drive("R10", 0, 32'h800, ALU_WORD, 0, 32'h7FC, 16'h0040, 32'd1, 32'd2, 1);
      drive("R10", 0, 32'h804, beq(16'hFFFC), 0, 32'h800, 16'hFFFC, 32'd3, 32'd3, 0);
      // Counter saturation
      for (int i = 0; i < 16; i++) begin
         drive("R8", 0, 32'h900 + 32'(i * 4), ALU_WORD, 1, 32'h1000, 16'h0004, 32'd7, 32'd8, 1);
      end
      drive("R8", 0, 32'hA00, ALU_WORD, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule